// File: doc/BRIEF.md
# Polled Terminal Byte Port

This block sits on a simple CPU load/store bus (16-bit address, read strobe, write strobe, byte data) and gives software a polled byte channel to a terminal. Keystrokes arriving from the host side are pushed into a small receive queue. The CPU polls a status location to learn whether input is waiting, and reads a data location to take the oldest byte. Each read of the data location removes that byte from the queue.

On the output side, a write to the transmit location sends the written byte toward a display model as a one-cycle valid/data pair. A write of any value to the clear location sends a one-cycle clear pulse. The block answers only its own four consecutive byte addresses, starting at a parameterised base (default 0x00F0). Every read result is registered and appears on `bus_rdata` in the cycle after the read strobe. The block does not store or render the output text.

Top module: `term_io_periph`

## Requirements
- R1: A read of base+0 (status) returns 0x01 on `bus_rdata` one cycle later when the receive queue holds at least one byte, and 0x00 when it is empty.
- R2: A read of base+1 (data) while the queue is non-empty returns the oldest queued byte one cycle later and removes it, so bytes leave in the order they were pushed.
- R3: A read of base+1 while the queue is empty returns 0x00 and leaves the queue unchanged.
- R4: A write to base+2 makes `out_valid` high for exactly one cycle, one cycle after the strobe, with `out_byte` equal to the written byte; `out_byte` holds its last value otherwise.
- R5: A write of any value to base+3 makes `out_clear` high for exactly one cycle, one cycle after the strobe, and does not raise `out_valid`.
- R6: A host push while the queue holds DEPTH bytes and no pop happens in the same cycle is dropped and sets `rx_overflow`, which stays set until reset.
- R7: A host push and a successful pop in the same cycle both take effect and leave the byte count unchanged, also when the queue is full (no overflow in that case).
- R8: Reads of any address other than base+0 and base+1 return 0x00, and writes to any address other than base+2 and base+3 produce no pulse and do not change the queue.
- R9: Synchronous active-high reset empties the queue and clears `rx_overflow`, `bus_rdata`, `out_valid`, `out_byte` and `out_clear`.
- R10: In a cycle following one with no read strobe, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU byte address |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| host_push | input | 1 | Host-side keystroke strobe |
| host_byte | input | 8 | Keystroke byte |
| out_valid | output | 1 | One-cycle character strobe toward the display |
| out_byte | output | 8 | Character byte toward the display |
| out_clear | output | 1 | One-cycle clear pulse toward the display |
| rx_overflow | output | 1 | Sticky flag: a keystroke was dropped on a full queue |

## Verification
The bench builds the block with a queue depth of 4 and the default base address, so the full-queue corner is reached with only a handful of pushes. That brings within reach the dropped push and sticky overflow, the push-and-pop swap on a full queue, and pointer wrap-around after several fill and drain passes. The decode is probed just outside the window on both sides and with a mismatching high byte.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

  // Which register of the window an access hits
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_STAT = 3'd1,
    SEL_DATA = 3'd2,
    SEL_TX   = 3'd3,
    SEL_CLR  = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/term_addr_decode.sv
module term_addr_decode
  import term_io_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic            hit;

  assign base_hi = BASE_ADDR[ADDR_W-1:2];
  assign hit     = (addr[ADDR_W-1:2] == base_hi);

  always_comb begin
    sel = SEL_NONE;
    if (hit) begin
      case (addr[1:0])
        2'd0:    sel = SEL_STAT;
        2'd1:    sel = SEL_DATA;
        2'd2:    sel = SEL_TX;
        default: sel = SEL_CLR;
      endcase
    end
  end

endmodule

// File: rtl/term_rx_fifo.sv
module term_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop_req,
  output logic [DATA_W-1:0]             head,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              ov_q;
  logic              pop_ok, push_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = mem[rd_ptr];
  assign count   = cnt_q;
  assign overflow = ov_q;

  // Storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push && !push_ok) ov_q <= 1'b1;
    end
  end

endmodule

// File: rtl/term_tx_port.sv
module term_tx_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_tx,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_clear
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_clear <= 1'b0;
    end else begin
      out_valid <= wr_tx;
      out_clear <= wr_clr;
      if (wr_tx) out_byte <= wdata;
    end
  end

endmodule

// File: rtl/term_io_periph.sv
module term_io_periph
  import term_io_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                DEPTH     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              host_push,
  input  logic [DATA_W-1:0] host_byte,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_clear,
  output logic              rx_overflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_sel_e          sel;
  logic [DATA_W-1:0] rx_head;
  logic              rx_empty, rx_full;
  logic [CNT_W-1:0]  rx_count;
  logic              pop_req, wr_tx, wr_clr;
  logic [DATA_W-1:0] rd_mux;

  term_addr_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign pop_req = bus_rd && (sel == SEL_DATA);
  assign wr_tx   = bus_wr && (sel == SEL_TX);
  assign wr_clr  = bus_wr && (sel == SEL_CLR);

  term_rx_fifo #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .push      (host_push),
    .push_data (host_byte),
    .pop_req   (pop_req),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full),
    .count     (rx_count),
    .overflow  (rx_overflow)
  );

  term_tx_port #(
    .DATA_W (DATA_W)
  ) u_tx (
    .clk       (clk),
    .rst       (rst),
    .wr_tx     (wr_tx),
    .wr_clr    (wr_clr),
    .wdata     (bus_wdata),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_clear (out_clear)
  );

  always_comb begin
    case (sel)
      SEL_STAT: rd_mux = {{(DATA_W-1){1'b0}}, ~rx_empty};
      SEL_DATA: rd_mux = rx_empty ? '0 : rx_head;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/term_io_periph_chk.sv
module term_io_periph_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                DEPTH     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F0
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       host_push,
  input logic                       out_valid,
  input logic [DATA_W-1:0]          out_byte,
  input logic                       out_clear,
  input logic                       rx_overflow,
  input logic [$clog2(DEPTH+1)-1:0] rx_count
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_DATA = BASE_ADDR + 1;
  localparam logic [ADDR_W-1:0] A_TX   = BASE_ADDR + 2;
  localparam logic [ADDR_W-1:0] A_CLR  = BASE_ADDR + 3;

  logic in_win;
  assign in_win = (bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);

  p_status_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=> (bus_rdata == DATA_W'($past(rx_count) != '0)));

  p_pop_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_DATA && rx_count != '0 && !host_push) |=> (rx_count == $past(rx_count) - 1'b1));

  p_empty_read_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_DATA && rx_count == '0 && !host_push) |=> (bus_rdata == '0 && rx_count == '0));

  p_tx_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_TX) |=> (out_valid && out_byte == $past(bus_wdata)));

  p_tx_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_TX) |=> (!out_valid && $stable(out_byte)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CLR) |=> (out_clear && !out_valid));

  p_ov_set_r6: assert property (@(posedge clk) disable iff (rst)
    (host_push && rx_count == CNT_W'(DEPTH) && !(bus_rd && bus_addr == A_DATA)) |=> rx_overflow);

  p_ov_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |=> rx_overflow);

  p_swap_r7: assert property (@(posedge clk) disable iff (rst)
    (host_push && bus_rd && bus_addr == A_DATA && rx_count != '0) |=> $stable(rx_count));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_win) |=> (bus_rdata == '0));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  p_count_bound: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CNT_W'(DEPTH));

endmodule

bind term_io_periph term_io_periph_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .DEPTH     (DEPTH),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .host_push   (host_push),
  .out_valid   (out_valid),
  .out_byte    (out_byte),
  .out_clear   (out_clear),
  .rx_overflow (rx_overflow),
  .rx_count    (rx_count)
);

// File: tb/term_io_periph_tb.sv
module term_io_periph_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam logic [15:0] A_STAT = 16'h00F0;
  localparam logic [15:0] A_DATA = 16'h00F1;
  localparam logic [15:0] A_TX   = 16'h00F2;
  localparam logic [15:0] A_CLR  = 16'h00F3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        host_push = 1'b0;
  logic [7:0]  host_byte = '0;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_clear;
  logic        rx_overflow;

  int total = 0;
  int bad   = 0;

  // Behavioural reference
  byte unsigned q[$];
  logic [7:0] m_rdata, m_byte;
  logic       m_valid, m_clear, m_ov;
  string      rd_tag, tx_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_io_periph #(.DEPTH(DEPTH), .BASE_ADDR(16'h00F0)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_push(host_push),
    .host_byte(host_byte), .out_valid(out_valid), .out_byte(out_byte),
    .out_clear(out_clear), .rx_overflow(rx_overflow)
  );

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%02h expected=0x%02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(rd_tag, "bus_rdata", bus_rdata, m_rdata);
    check(tx_tag, "out_valid", {7'b0, out_valid}, {7'b0, m_valid});
    check(tx_tag, "out_byte", out_byte, m_byte);
    check("R5", "out_clear", {7'b0, out_clear}, {7'b0, m_clear});
    check("R6", "rx_overflow", {7'b0, rx_overflow}, {7'b0, m_ov});
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_rd = 0; bus_wr = 0; host_push = 0;
    @(posedge clk); @(posedge clk);
    q.delete(); m_rdata = 0; m_byte = 0; m_valid = 0; m_clear = 0; m_ov = 0;
    rd_tag = "R9"; tx_tag = "R9";
    @(negedge clk);
    rst = 1'b0;
    check("R9", "bus_rdata", bus_rdata, 8'h00);
    check("R9", "out_valid", {7'b0, out_valid}, 8'h00);
    check("R9", "out_byte", out_byte, 8'h00);
    check("R9", "out_clear", {7'b0, out_clear}, 8'h00);
    check("R9", "rx_overflow", {7'b0, rx_overflow}, 8'h00);
  endtask

  // One bus cycle: drive, model at the edge, compare at the falling edge
  task automatic cyc(input bit p, input logic [7:0] hb, input bit rd, input bit wr,
                     input logic [15:0] a, input logic [7:0] wd);
    bit popd;
    host_push = p; host_byte = hb; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    popd = 0;
    m_rdata = 8'h00; rd_tag = "R10";
    if (rd) begin
      if (a == A_STAT) begin
        m_rdata = (q.size() != 0) ? 8'h01 : 8'h00; rd_tag = "R1";
      end else if (a == A_DATA) begin
        if (q.size() != 0) begin m_rdata = q[0]; popd = 1; rd_tag = p ? "R7" : "R2"; end
        else begin m_rdata = 8'h00; rd_tag = "R3"; end
      end else rd_tag = "R8";
    end
    if (popd) void'(q.pop_front());
    if (p) begin
      if (q.size() < DEPTH) q.push_back(hb);
      else m_ov = 1;
    end
    m_valid = wr && (a == A_TX);
    if (m_valid) m_byte = wd;
    m_clear = wr && (a == A_CLR);
    tx_tag = (wr && a != A_TX) ? "R8" : "R4";
    if (wr && a == A_CLR) tx_tag = "R5";
    @(negedge clk);
    compare_all();
    host_push = 0; bus_rd = 0; bus_wr = 0;
  endtask

  task automatic idle();
    cyc(0, 8'h00, 0, 0, 16'h0000, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R1 / R3 on an empty queue
    cyc(0, 0, 1, 0, A_STAT, 0);
    cyc(0, 0, 1, 0, A_DATA, 0);
    idle();

    // R2 order
    cyc(1, 8'h41, 0, 0, 0, 0);
    cyc(1, 8'h42, 0, 0, 0, 0);
    cyc(1, 8'h43, 1, 0, A_STAT, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, A_DATA, 0);
    cyc(0, 0, 1, 0, A_STAT, 0);
    cyc(0, 0, 1, 0, A_DATA, 0);

    // R4 back-to-back characters, R5 clear
    cyc(0, 0, 0, 1, A_TX, 8'h48);
    cyc(0, 0, 0, 1, A_TX, 8'h69);
    idle();
    cyc(0, 0, 0, 1, A_CLR, 8'hA5);
    cyc(0, 0, 0, 1, A_CLR, 8'h00);
    idle();

    // R6 fill and overflow
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    idle(); idle();

    // R7 push and pop on a full queue, then drain
    cyc(1, 8'h77, 1, 0, A_DATA, 0);
    cyc(1, 8'h78, 1, 0, A_DATA, 0);
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 1, 0, A_DATA, 0);
    // R7 on one entry, and on empty (pop refused, push kept)
    cyc(1, 8'h31, 0, 0, 0, 0);
    cyc(1, 8'h32, 1, 0, A_DATA, 0);
    cyc(0, 0, 1, 0, A_DATA, 0);
    cyc(1, 8'h33, 1, 0, A_DATA, 0);
    cyc(0, 0, 1, 0, A_STAT, 0);

    // R8 unmapped accesses
    cyc(0, 0, 1, 0, 16'h01F1, 0);
    cyc(0, 0, 1, 0, 16'h00F4, 0);
    cyc(0, 0, 1, 0, 16'h00EF, 0);
    cyc(0, 0, 1, 0, A_TX, 0);
    cyc(0, 0, 1, 0, A_CLR, 0);
    cyc(0, 0, 0, 1, A_STAT, 8'h55);
    cyc(0, 0, 0, 1, A_DATA, 8'h55);
    cyc(0, 0, 0, 1, 16'h10F2, 8'h66);
    cyc(0, 0, 0, 1, 16'h00F7, 8'h66);
    cyc(0, 0, 1, 0, A_STAT, 0);
    cyc(0, 0, 1, 0, A_DATA, 0);
    cyc(0, 0, 1, 0, A_STAT, 0);

    // Mixed traffic with wrap-around
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(lf[0], lf[15:8], lf[1] & ~lf[2], lf[3], {14'h003C, lf[5:4]}, lf[11:4]);
      end
    end

    // R9 reset clears sticky overflow and queue
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, 8'h90, 0, 0, 0, 0);
    do_reset();
    cyc(0, 0, 1, 0, A_STAT, 0);
    cyc(0, 0, 1, 0, A_DATA, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule